// File: doc/BRIEF.md
# Address-Munging Endian Load/Store Unit

This unit sits between a processor's load/store pipeline and a data memory that is 64 bits wide with big-endian byte lanes. It turns an effective address, an operand size and a read or write strobe into a memory byte address, per-lane byte enables and lane-placed write data. On the return path it lifts the addressed operand out of the memory word and zero-extends it.

A mode input chooses big-endian or pseudo-little-endian operation for each access. In the little-endian mode no bytes are swapped. Instead, the low three address bits are flipped by a constant that depends on the operand size. As a result, a doubleword reads back bit-identical whichever mode wrote it. The mode may change between any two accesses, and each access uses the mode present on the cycle it was accepted. Accesses that are not naturally aligned are reported and blocked rather than split.

Top module: `endian_lsu`

## Requirements
- R1: With `le_mode` low, an access drives `mem_addr` equal to `eff_addr`.
- R2: With `le_mode` high, `mem_addr` bits [2:0] are `eff_addr` bits [2:0] XOR a constant chosen by `op_size` (0 byte: 3'b111, 1 halfword: 3'b110, 2 word: 3'b100, 3 doubleword: 3'b000). The upper bits pass unchanged.
- R3: `mem_be` bit i enables memory lane i, which is data bits [63-8i:56-8i]. For an accepted access, the set bits are the lanes starting at `mem_addr[2:0]`, one lane per operand byte. When no access is accepted, `mem_be` is zero.
- R4: On a write, the operand is the low 8·n bits of `st_data` (n = operand bytes). Its most significant byte goes into lane `mem_addr[2:0]` and its following bytes into the following lanes. All other lanes of `mem_wdata` are zero.
- R5: An access whose `eff_addr` is not a multiple of its size raises `align_err` in the same cycle. It produces neither `mem_we` nor `mem_re`, leaves memory unchanged and returns no load.
- R6: `ld_valid` is high in exactly the cycle after a cycle with `mem_re` high. `ld_data` is formed from `mem_rdata` in that cycle.
- R7: `ld_data` holds the operand bytes taken from the addressed lanes in big-endian order (lowest lane is most significant), zero-extended to 64 bits.
- R8: A load uses the mode present on the cycle it was accepted. Changing `le_mode` while its data is pending does not alter that data.
- R9: A doubleword stored at an address in either mode reads back bit-identical from that address in the other mode.
- R10: When `wr_en` and `rd_en` are both high, only the write is performed: `mem_re` stays low and no load returns.
- R11: While `rst_n` is low, `ld_valid` is low.
- R12: A word written in little-endian mode at address 0, then read in that mode as halfwords, returns its low half from address 0 and its high half from address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Load request strobe |
| wr_en | input | 1 | Store request strobe |
| le_mode | input | 1 | 1 selects pseudo-little-endian addressing |
| op_size | input | 2 | Operand size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| eff_addr | input | ADDR_W | Effective byte address |
| st_data | input | DATA_W | Store operand, right-justified |
| mem_addr | output | ADDR_W | Memory byte address after munging |
| mem_be | output | DATA_W/8 | Byte-lane enables, bit i = lane i |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | DATA_W | Lane-placed write data |
| mem_rdata | input | DATA_W | Memory read word, one cycle after mem_re |
| ld_valid | output | 1 | Load data valid |
| ld_data | output | DATA_W | Extracted, zero-extended load operand |
| align_err | output | 1 | Misaligned access flag |

## Verification
A load's data return and the next request's address munging can land in the same cycle, and that next request may carry a flipped `le_mode`. The bench provokes this by issuing requests back to back, with the mode chosen at random per access. It also includes a directed case in which a little-endian byte load is followed at once by a big-endian store. The returned operand is judged against the reference byte-array model evaluated with the mode captured at issue. In the same cycle, the new request's address, enables and write lanes are judged against the new mode.

// File: rtl/endian_lsu_pkg.sv
`timescale 1ns/1ps
package endian_lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } op_size_e;
endpackage

// File: rtl/lsu_addr_munge.sv
`timescale 1ns/1ps
// Address translation: size decode, alignment test, low-bit flip, lane mask.
module lsu_addr_munge #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8,
  parameter int OFS_W  = 3,
  parameter int SZ_W   = 2
) (
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [SZ_W-1:0]   op_size,
  input  logic              le_mode,
  input  logic              enable,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [OFS_W-1:0]  lane_ofs,
  output logic [OFS_W:0]    nbytes,
  output logic [LANES-1:0]  lane_mask,
  output logic              misaligned
);
  localparam int CW = OFS_W + 2;

  logic [OFS_W-1:0] lo_mask;
  logic [OFS_W-1:0] flip;
  logic [CW-1:0]    span_end;

  always_comb begin
    nbytes     = (OFS_W+1)'(1) << op_size;
    lo_mask    = OFS_W'(nbytes - (OFS_W+1)'(1));
    // flipping only the bits above the size's own offset keeps alignment intact
    flip       = le_mode ? ~lo_mask : '0;
    lane_ofs   = eff_addr[OFS_W-1:0] ^ flip;
    misaligned = |(eff_addr[OFS_W-1:0] & lo_mask);
    phys_addr  = {eff_addr[ADDR_W-1:OFS_W], lane_ofs};
    span_end   = CW'(lane_ofs) + CW'(nbytes);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [CW-1:0] IDX = CW'(i);
    assign lane_mask[i] = enable && (CW'(lane_ofs) <= IDX) && (IDX < span_end);
  end
endmodule

// File: rtl/lsu_store_place.sv
`timescale 1ns/1ps
// Places a right-justified store operand onto big-endian memory lanes.
module lsu_store_place #(
  parameter int DATA_W = 64,
  parameter int LANES  = 8,
  parameter int OFS_W  = 3
) (
  input  logic [DATA_W-1:0] st_data,
  input  logic [OFS_W-1:0]  lane_ofs,
  input  logic [OFS_W:0]    nbytes,
  input  logic [LANES-1:0]  lane_mask,
  input  logic              enable,
  output logic [DATA_W-1:0] wdata
);
  localparam int CW = OFS_W + 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CW-1:0]   src;
    logic [7:0]      byte_v;
    always_comb begin
      // operand byte index counted from its least significant byte
      src    = CW'(lane_ofs) + CW'(nbytes) - CW'(1) - CW'(i);
      byte_v = st_data[8*int'(src[OFS_W-1:0]) +: 8];
      wdata[(LANES-1-i)*8 +: 8] = (enable && lane_mask[i]) ? byte_v : 8'h00;
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
// Captures lane position of an accepted load, then extracts its operand.
module lsu_load_extract #(
  parameter int DATA_W = 64,
  parameter int LANES  = 8,
  parameter int OFS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [OFS_W-1:0]  lane_ofs,
  input  logic [OFS_W:0]    nbytes,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  localparam int CW = OFS_W + 2;

  logic             pend_q, pend_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [OFS_W:0]   nb_q, nb_d;
  logic             cap_en;

  // next state
  always_comb begin
    cap_en = issue;
    pend_d = issue;
    ofs_d  = cap_en ? lane_ofs : ofs_q;
    nb_d   = cap_en ? nbytes   : nb_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ofs_q  <= '0;
      nb_q   <= '0;
    end else begin
      pend_q <= pend_d;
      ofs_q  <= ofs_d;
      nb_q   <= nb_d;
    end
  end

  assign ld_valid = pend_q;

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    localparam logic [CW-1:0] KIDX = CW'(k);
    logic [CW-1:0] lane;
    always_comb begin
      lane = CW'(ofs_q) + CW'(nb_q) - CW'(1) - KIDX;
      ld_data[8*k +: 8] = (KIDX < CW'(nb_q))
                          ? mem_rdata[(LANES-1-int'(lane[OFS_W-1:0]))*8 +: 8]
                          : 8'h00;
    end
  end
endmodule

// File: rtl/endian_lsu.sv
`timescale 1ns/1ps
module endian_lsu #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic                le_mode,
  input  logic [1:0]          op_size,
  input  logic [ADDR_W-1:0]   eff_addr,
  input  logic [DATA_W-1:0]   st_data,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic                mem_we,
  output logic                mem_re,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                ld_valid,
  output logic [DATA_W-1:0]   ld_data,
  output logic                align_err
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);
  localparam int SZ_W  = 2;

  logic             access, accept, misaligned;
  logic [OFS_W-1:0] lane_ofs;
  logic [OFS_W:0]   nbytes;

  always_comb begin
    access    = rd_en | wr_en;
    accept    = access & ~misaligned;
    align_err = access & misaligned;
    mem_we    = wr_en & accept;
    // a double strobe is a write; the read half is dropped
    mem_re    = rd_en & ~wr_en & accept;
  end

  lsu_addr_munge #(
    .ADDR_W(ADDR_W), .LANES(LANES), .OFS_W(OFS_W), .SZ_W(SZ_W)
  ) u_munge (
    .eff_addr  (eff_addr),
    .op_size   (op_size),
    .le_mode   (le_mode),
    .enable    (accept),
    .phys_addr (mem_addr),
    .lane_ofs  (lane_ofs),
    .nbytes    (nbytes),
    .lane_mask (mem_be),
    .misaligned(misaligned)
  );

  lsu_store_place #(
    .DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)
  ) u_place (
    .st_data  (st_data),
    .lane_ofs (lane_ofs),
    .nbytes   (nbytes),
    .lane_mask(mem_be),
    .enable   (mem_we),
    .wdata    (mem_wdata)
  );

  lsu_load_extract #(
    .DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)
  ) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (mem_re),
    .lane_ofs (lane_ofs),
    .nbytes   (nbytes),
    .mem_rdata(mem_rdata),
    .ld_valid (ld_valid),
    .ld_data  (ld_data)
  );
endmodule

// File: rtl/endian_lsu_chk.sv
`timescale 1ns/1ps
module endian_lsu_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_en,
  input logic                wr_en,
  input logic                le_mode,
  input logic [1:0]          op_size,
  input logic [ADDR_W-1:0]   eff_addr,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic                mem_we,
  input logic                mem_re,
  input logic                ld_valid,
  input logic [DATA_W-1:0]   ld_data,
  input logic                align_err
);
  import endian_lsu_pkg::*;

  a_r1_be_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && !le_mode) |-> mem_addr == eff_addr);

  a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> mem_addr[ADDR_W-1:3] == eff_addr[ADDR_W-1:3]);

  a_r2_byte_flip: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && le_mode && op_size == SZ_BYTE)
      |-> mem_addr[2:0] == ~eff_addr[2:0]);

  a_r9_dword_same: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && op_size == SZ_DWORD) |-> mem_addr == eff_addr);

  a_r3_be_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> $countones(mem_be) == (1 << op_size));

  a_r3_be_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we || mem_re) |-> mem_be == '0);

  a_r5_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_we && !mem_re));

  a_r6_ld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ld_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> !ld_valid);

  a_r7_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && op_size == SZ_BYTE) |=> ld_data[DATA_W-1:8] == '0);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mem_re);

  always_comb begin
    if (!rst_n) a_r11_reset_idle: assert (!ld_valid);
  end
endmodule

bind endian_lsu endian_lsu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .le_mode(le_mode),
  .op_size(op_size), .eff_addr(eff_addr), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_we(mem_we), .mem_re(mem_re), .ld_valid(ld_valid), .ld_data(ld_data),
  .align_err(align_err)
);

// File: tb/endian_lsu_tb_top.sv
`timescale 1ns/1ps
module endian_lsu_tb_top;
  logic        clk;
  logic        rst_n;
  logic        rd_en, wr_en, le_mode;
  logic [1:0]  op_size;
  logic [31:0] eff_addr;
  logic [63:0] st_data;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic        mem_we, mem_re;
  logic [63:0] mem_wdata, mem_rdata;
  logic        ld_valid;
  logic [63:0] ld_data;
  logic        align_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  endian_lsu dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .le_mode(le_mode),
    .op_size(op_size), .eff_addr(eff_addr), .st_data(st_data),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_data(ld_data), .align_err(align_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // memory: 8 doublewords, one-cycle read latency
  logic [63:0] mem [0:7];
  logic [63:0] rdata_q;
  assign mem_rdata = rdata_q;
  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 64'h0;
    rdata_q = 64'h0;
  end
  always @(posedge clk) begin
    if (mem_we)
      for (int i = 0; i < 8; i++)
        if (mem_be[i]) mem[mem_addr[5:3]][(7-i)*8 +: 8] <= mem_wdata[(7-i)*8 +: 8];
    if (mem_re) rdata_q <= mem[mem_addr[5:3]];
  end

  // reference byte array, indexed by physical byte address
  logic [7:0] ref_mem [0:63];
  initial for (int i = 0; i < 64; i++) ref_mem[i] = 8'h00;

  function automatic logic [2:0] flip_of(input logic [1:0] sz);
    case (sz)
      2'd0: return 3'b111;
      2'd1: return 3'b110;
      2'd2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [31:0] phys_of(input logic [31:0] a, input logic [1:0] sz, input bit le);
    return le ? {a[31:3], a[2:0] ^ flip_of(sz)} : a;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  bit          exp_pend = 0;
  logic [63:0] exp_ld   = '0;
  string       exp_tag  = "R7";
  logic [63:0] obs_ld   = '0;

  // drive one request at a falling edge, check its comb outputs and the
  // load return of the previous request
  task automatic step(input bit we, input bit re, input bit le, input logic [31:0] a,
                      input logic [1:0] sz, input logic [63:0] d, input string ltag);
    int nb;
    bit mis, acc, e_we, e_re;
    logic [31:0] p;
    logic [7:0]  e_be;
    logic [63:0] e_wd, v;
    @(negedge clk);
    wr_en = we; rd_en = re; le_mode = le; eff_addr = a; op_size = sz; st_data = d;
    #1;
    obs_ld = ld_data;
    chk(ld_valid == exp_pend, "R6 ld_valid", 64'(ld_valid), 64'(exp_pend));
    if (exp_pend) chk(ld_data == exp_ld, exp_tag, ld_data, exp_ld);
    nb   = 1 << sz;
    mis  = (a[2:0] & 3'(nb - 1)) != 0;
    acc  = we | re;
    p    = phys_of(a, sz, le);
    e_we = we & !mis;
    e_re = re & !we & !mis;
    chk(align_err == (acc & mis), "R5 align_err", 64'(align_err), 64'(acc & mis));
    chk(mem_we == e_we, "R5 mem_we", 64'(mem_we), 64'(e_we));
    chk(mem_re == e_re, "R10 mem_re", 64'(mem_re), 64'(e_re));
    if (acc) chk(mem_addr == p, le ? "R2 mem_addr" : "R1 mem_addr", 64'(mem_addr), 64'(p));
    e_be = '0;
    e_wd = '0;
    if (e_we || e_re)
      for (int j = 0; j < nb; j++) e_be[p[2:0] + 3'(j)] = 1'b1;
    chk(mem_be == e_be, "R3 mem_be", 64'(mem_be), 64'(e_be));
    if (e_we) begin
      for (int j = 0; j < nb; j++) begin
        e_wd[(7 - (p[2:0] + j)) * 8 +: 8] = d[(nb - 1 - j) * 8 +: 8];
        ref_mem[p[5:0] + 6'(j)] = d[(nb - 1 - j) * 8 +: 8];
      end
      chk(mem_wdata == e_wd, "R4 mem_wdata", mem_wdata, e_wd);
    end
    v = '0;
    for (int j = 0; j < nb; j++) v = (v << 8) | 64'(ref_mem[p[5:0] + 6'(j)]);
    exp_pend = e_re;
    exp_ld   = v;
    exp_tag  = ltag;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rd_en = 0; wr_en = 0; le_mode = 0; op_size = 0; eff_addr = 0; st_data = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(ld_valid == 1'b0, "R11 ld_valid in reset", 64'(ld_valid), 64'h0);
    chk(mem_we == 1'b0, "R11 mem_we in reset", 64'(mem_we), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R12: little-endian word then halfword reads
    step(1, 0, 1, 32'h0, 2'd2, 64'h11223344, "R7");
    step(0, 1, 1, 32'h0, 2'd1, 64'h0, "R12");
    step(0, 1, 1, 32'h2, 2'd1, 64'h0, "R12");
    chk(obs_ld == 64'h3344, "R12 half at 0", obs_ld, 64'h3344);
    step(0, 0, 0, 32'h0, 2'd0, 64'h0, "R7");
    chk(obs_ld == 64'h1122, "R12 half at 2", obs_ld, 64'h1122);

    // R9: doubleword cross-mode read-back, both directions
    step(1, 0, 0, 32'h8, 2'd3, 64'h0102030405060708, "R7");
    step(0, 1, 1, 32'h8, 2'd3, 64'h0, "R9");
    step(1, 0, 1, 32'h10, 2'd3, 64'hA1B2C3D4E5F60718, "R7");
    chk(obs_ld == 64'h0102030405060708, "R9 BE->LE", obs_ld, 64'h0102030405060708);
    step(0, 1, 0, 32'h10, 2'd3, 64'h0, "R9");
    step(0, 0, 0, 32'h0, 2'd0, 64'h0, "R7");
    chk(obs_ld == 64'hA1B2C3D4E5F60718, "R9 LE->BE", obs_ld, 64'hA1B2C3D4E5F60718);

    // R8: mode flips while a little-endian byte load is outstanding
    step(0, 1, 1, 32'h3, 2'd0, 64'h0, "R8");
    step(1, 0, 0, 32'h28, 2'd1, 64'hBEEF, "R8");

    // R10: both strobes
    step(1, 1, 0, 32'h20, 2'd2, 64'hCAFEF00D, "R10");
    step(0, 1, 0, 32'h20, 2'd2, 64'h0, "R10");

    // R5: misaligned write leaves memory intact
    step(1, 0, 0, 32'h21, 2'd1, 64'hFFFF, "R5");
    step(0, 1, 0, 32'h20, 2'd2, 64'h0, "R5");
    step(0, 1, 1, 32'h6, 2'd2, 64'h0, "R5");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      int          kind;
      a    = $urandom;
      sz   = 2'($urandom_range(0, 3));
      kind = $urandom_range(0, 9);
      if ($urandom_range(0, 3) != 0) a = a & ~32'((1 << sz) - 1);
      step(kind < 4, kind >= 4 && kind < 9 || kind == 3, 1'($urandom_range(0, 1)), a, sz,
           {$urandom, $urandom}, "R7");
    end
    step(0, 0, 0, 32'h0, 2'd0, 64'h0, "R7");
    step(0, 0, 0, 32'h0, 2'd0, 64'h0, "R7");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule